// File: doc/BRIEF.md
# Online Floating-Point Adder Result Synchronizer

This block is the output stage of a digit-serial floating-point adder that works most significant digit first in borrow-save form. Each result arrives as one stream of two-bit digits per frame. The frame holds the unsigned exponent (the larger of the two operand exponents), then the carry digit of the mantissa sum, then the mantissa-sum digits. The block decides whether the exponent must grow by one. It makes that decision from two digits only: the carry and the leading mantissa digit. It grows the exponent only when the carry cannot be absorbed. In that case it keeps the carry as the new leading digit and drops the last mantissa digit. Otherwise it folds the carry into the leading digit and the carry disappears.

A zero digit may enter with either zero code. The block always sends a significant zero as `11`, so the code `00` is never a valid output digit. On both sides, an empty slot is shown by a low valid. Both streams use valid/ready. A digit moves on a cycle where valid and ready are both high. The output holds its valid and its digit while ready is low. The input is not accepted while the adjusted exponent is being sent out. Otherwise input acceptance follows output space.

The exponent is held back until the leading mantissa digit has been seen. The increment is applied in parallel across the held exponent before it is sent. A flag reports an exponent that wrapped past its largest value. Both `EXP_W` and `MAN_L` must be at least 2.

Top module: `ola_sync`

## Requirements
- R1: Input frame: `EXP_W` exponent digits, MSD first, with `10` meaning 1 and `00` or `11` meaning 0. Then one carry digit. Then `MAN_L` mantissa digits. Each output frame holds exactly `EXP_W` exponent digits followed by exactly `MAN_L` mantissa digits.
- R2: The exponent is incremented exactly when the carry is nonzero and the leading mantissa digit is not its negation. The output exponent is the input exponent plus that increment, modulo 2^`EXP_W`, MSD first.
- R3: `ovf` is 0 after reset. It is updated only when a frame's leading mantissa digit is accepted. It is then 1 exactly when that frame incremented an all-ones exponent, and it holds its value until the next such update.
- R4: When incremented, the output mantissa is the carry followed by input mantissa digits 1 to `MAN_L`-1. Input digit `MAN_L` is consumed and discarded.
- R5: When not incremented, the first output mantissa digit is the carry if the carry is nonzero (the pairs +1,-1 and -1,+1 become +1 and -1), and the leading input digit otherwise. Input digits 2 to `MAN_L` follow unchanged.
- R6: Output digit codes: `10` is +1, `01` is -1, `11` is 0. The code `00` is never valid on the output.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_digit` stay unchanged. `in_ready` is low while the exponent is being sent out. No digit is lost or duplicated under back-pressure.
- R8: After reset `out_valid` is 0, `ovf` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input digit present |
| in_ready | output | 1 | Block accepts the input digit this cycle |
| in_digit | input | 2 | Borrow-save input digit {plus, minus} |
| out_valid | output | 1 | Output digit present |
| out_ready | input | 1 | Consumer takes the output digit this cycle |
| out_digit | output | 2 | Borrow-save output digit {plus, minus} |
| ovf | output | 1 | Exponent wrapped on the last increment |

## Verification
A wrong increment decision shows up as an exponent that is off by one. It appears on the very first output digit of the frame whose bit flips, so it surfaces within `EXP_W` output digits after the leading mantissa digit is accepted. The same wrong decision also shifts the mantissa by one position, so most later digits of that frame disagree too. A phase counter that is off by one shows up at the frame edge, as a missing or extra digit. From then on every later digit is misaligned, which the scoreboard detects at once. A stuck or early `ovf` is compared at the first exponent digit of every frame. Back-pressure is randomized so that a lost or repeated digit breaks the running comparison.

// File: rtl/ola_sync_pkg.sv
package ola_sync_pkg;
  typedef logic [1:0] bsd_t;  // {plus, minus}

  typedef enum logic [2:0] {
    PH_EXP, PH_CARRY, PH_LEAD, PH_EMIT_EXP, PH_MANT, PH_DROP
  } phase_e;

  localparam bsd_t BSD_POS  = 2'b10;
  localparam bsd_t BSD_NEG  = 2'b01;
  localparam bsd_t BSD_ZERO = 2'b11;

  function automatic logic signed [1:0] bsd_val(bsd_t d);
    if (d == BSD_POS) return 2'sd1;
    if (d == BSD_NEG) return -2'sd1;
    return 2'sd0;
  endfunction

  function automatic bsd_t bsd_enc(logic signed [1:0] v);
    if (v == 2'sd1) return BSD_POS;
    if (v == -2'sd1) return BSD_NEG;
    return BSD_ZERO;
  endfunction
endpackage

// File: rtl/ola_sync_decide.sv
module ola_sync_decide
  import ola_sync_pkg::*;
(
  input  bsd_t carry_i,
  input  bsd_t lead_i,
  output logic bump_o,
  output bsd_t first_o
);
  logic signed [1:0] cv, lv;

  always_comb begin
    cv = bsd_val(carry_i);
    lv = bsd_val(lead_i);
    bump_o  = (cv != 2'sd0) && (lv != -cv);
    first_o = (cv != 2'sd0) ? bsd_enc(cv) : bsd_enc(lv);
  end
endmodule

// File: rtl/ola_sync_incr.sv
module ola_sync_incr #(
  parameter int W = 12
) (
  input  logic [W-1:0] val_i,
  input  logic         bump_i,
  output logic [W-1:0] sum_o,
  output logic         wrap_o
);
  logic [W:0] chain;
  assign chain[0] = bump_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]     = val_i[i] ^ chain[i];
    assign chain[i + 1] = val_i[i] & chain[i];
  end

  assign wrap_o = chain[W];
endmodule

// File: rtl/ola_sync.sv
module ola_sync
  import ola_sync_pkg::*;
#(
  parameter int EXP_W = 12,
  parameter int MAN_L = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_digit,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_digit,
  output logic       ovf
);
  localparam int CNT_MAX = (EXP_W > MAN_L) ? EXP_W : MAN_L;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] EXP_LAST = CW'(EXP_W - 1);
  localparam logic [CW-1:0] MAN_LAST = CW'(MAN_L - 1);

  phase_e          ph_q;
  logic [CW-1:0]   cnt_q;
  logic [EXP_W-1:0] exp_q, oexp_q;
  bsd_t            carry_q, lead_q, first_q;
  logic            bump_q;
  logic            ov_q, ovf_q;
  bsd_t            od_q;

  logic            dec_bump, inc_wrap;
  bsd_t            dec_first, lead_norm, mant_src, load_d;
  logic [EXP_W-1:0] inc_sum;
  logic            can_load, need_in, load, take, emit_exp, decide_fire;

  ola_sync_decide u_dec (
    .carry_i (carry_q),
    .lead_i  (in_digit),
    .bump_o  (dec_bump),
    .first_o (dec_first)
  );

  ola_sync_incr #(.W(EXP_W)) u_inc (
    .val_i  (exp_q),
    .bump_i (dec_bump),
    .sum_o  (inc_sum),
    .wrap_o (inc_wrap)
  );

  always_comb begin
    lead_norm = bsd_enc(bsd_val(in_digit));
    can_load  = !ov_q || out_ready;
    emit_exp  = (ph_q == PH_EMIT_EXP);
    need_in   = bump_q ? (cnt_q >= CW'(2)) : (cnt_q != '0);
    if (cnt_q == '0)                  mant_src = first_q;
    else if (bump_q && cnt_q == CW'(1)) mant_src = lead_q;
    else                              mant_src = lead_norm;

    in_ready = 1'b0;
    load     = 1'b0;
    load_d   = BSD_ZERO;
    unique case (ph_q)
      PH_EMIT_EXP: begin
        load   = can_load;
        load_d = oexp_q[EXP_W-1] ? BSD_POS : BSD_ZERO;
      end
      PH_MANT: begin
        in_ready = can_load && need_in;
        load     = can_load && (!need_in || in_valid);
        load_d   = mant_src;
      end
      default: in_ready = 1'b1;
    endcase
    take        = in_valid && in_ready;
    decide_fire = take && (ph_q == PH_LEAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_EXP;
      cnt_q   <= '0;
      exp_q   <= '0;
      oexp_q  <= '0;
      carry_q <= BSD_ZERO;
      lead_q  <= BSD_ZERO;
      first_q <= BSD_ZERO;
      bump_q  <= 1'b0;
      ov_q    <= 1'b0;
      od_q    <= BSD_ZERO;
      ovf_q   <= 1'b0;
    end else begin
      if (load) begin
        ov_q <= 1'b1;
        od_q <= load_d;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end

      case (ph_q)
        PH_EXP: if (take) begin
          exp_q <= {exp_q[EXP_W-2:0], in_digit == BSD_POS};
          if (cnt_q == EXP_LAST) begin
            cnt_q <= '0;
            ph_q  <= PH_CARRY;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_CARRY: if (take) begin
          carry_q <= in_digit;
          ph_q    <= PH_LEAD;
        end
        PH_LEAD: if (decide_fire) begin
          bump_q  <= dec_bump;
          first_q <= dec_first;
          lead_q  <= lead_norm;
          oexp_q  <= inc_sum;
          ovf_q   <= inc_wrap;
          cnt_q   <= '0;
          ph_q    <= PH_EMIT_EXP;
        end
        PH_EMIT_EXP: if (load) begin
          oexp_q <= oexp_q << 1;
          if (cnt_q == EXP_LAST) begin
            cnt_q <= '0;
            ph_q  <= PH_MANT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_MANT: if (load) begin
          if (cnt_q == MAN_LAST) begin
            cnt_q <= '0;
            ph_q  <= bump_q ? PH_DROP : PH_EXP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_DROP: if (take) ph_q <= PH_EXP;
        default: ph_q <= PH_EXP;
      endcase
    end
  end

  assign out_valid = ov_q;
  assign out_digit = od_q;
  assign ovf       = ovf_q;
endmodule

// File: rtl/ola_sync_chk.sv
module ola_sync_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_digit,
  input logic       ovf,
  input logic       emit_exp,
  input logic       decide_fire
);
  // R7: a stalled output digit stays put
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_digit));

  // R6: the null code never leaves as a valid digit
  a_r6_no_null: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_digit != 2'b00);

  // R7: no input taken while the exponent is sent
  a_r7_no_take_in_exp: assert property (@(posedge clk) disable iff (rst)
    emit_exp |-> !in_ready);

  // R3: flag moves only right after a decision
  a_r3_ovf_on_decide: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovf) |-> $past(decide_fire));
endmodule

bind ola_sync ola_sync_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_digit   (out_digit),
  .ovf         (ovf),
  .emit_exp    (emit_exp),
  .decide_fire (decide_fire)
);

// File: tb/ola_sync_test.sv
`timescale 1ns/1ps
module ola_sync_test;
  localparam int EXP_W = 12;
  localparam int MAN_L = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_digit = 2'b00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [1:0] out_digit;
  logic       ovf;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  bp_en = 0;
  int  seed = 7;
  int  zero_alt = 0;
  int  oidx = 0;

  logic [1:0] exp_dq[$];
  string      tag_q[$];
  bit         ovf_q[$];

  always #2.5 clk = ~clk;

  ola_sync #(.EXP_W(EXP_W), .MAN_L(MAN_L)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_digit(in_digit), .out_valid(out_valid), .out_ready(out_ready),
    .out_digit(out_digit), .ovf(ovf)
  );

  function automatic logic [1:0] enc_out(int v);
    return (v > 0) ? 2'b10 : (v < 0) ? 2'b01 : 2'b11;
  endfunction

  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32'h7fff;
  endfunction

  function automatic logic [1:0] enc_in(int v);
    if (v > 0) return 2'b10;
    if (v < 0) return 2'b01;
    zero_alt++;
    return zero_alt[0] ? 2'b00 : 2'b11;
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // back-pressure source
  always @(posedge clk) begin
    #1;
    out_ready = bp_en ? ((next_rand() % 3) != 0) : 1'b1;
  end

  task automatic send_digit(input logic [1:0] d);
    bit got;
    in_valid = 1'b1;
    in_digit = d;
    got = 0;
    while (!got) begin
      @(negedge clk);
      got = in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [EXP_W-1:0] e, input int c, input int lead,
                            input string mtag);
    int mv[MAN_L];
    bit inc;
    logic [EXP_W:0] esum;
    mv[0] = lead;
    for (int i = 1; i < MAN_L; i++) mv[i] = (next_rand() % 3) - 1;
    inc = (c != 0) && (lead != -c);               // R2 rule
    esum = {1'b0, e} + (inc ? 1 : 0);
    ovf_q.push_back(esum[EXP_W]);                 // R3 expectation
    for (int i = EXP_W - 1; i >= 0; i--) begin
      exp_dq.push_back(esum[i] ? 2'b10 : 2'b11);
      tag_q.push_back("R2");
    end
    if (inc) begin                                // R4 layout
      exp_dq.push_back(enc_out(c)); tag_q.push_back(mtag);
      for (int i = 0; i < MAN_L - 1; i++) begin
        exp_dq.push_back(enc_out(mv[i])); tag_q.push_back(mtag);
      end
    end else begin                                // R5 layout
      exp_dq.push_back(enc_out(c != 0 ? c : lead)); tag_q.push_back(mtag);
      for (int i = 1; i < MAN_L; i++) begin
        exp_dq.push_back(enc_out(mv[i])); tag_q.push_back(mtag);
      end
    end
    for (int i = EXP_W - 1; i >= 0; i--)
      send_digit(e[i] ? 2'b10 : enc_in(0));
    send_digit(enc_in(c));
    for (int i = 0; i < MAN_L; i++) send_digit(enc_in(mv[i]));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_dq.size() == 0) begin
        check("R1 unexpected digit", int'(out_digit), -1);
      end else begin
        automatic logic [1:0] ed = exp_dq.pop_front();
        automatic string tg = tag_q.pop_front();
        check(tg, int'(out_digit), int'(ed));
        if (oidx == 0 && ovf_q.size() != 0) check("R3 ovf", int'(ovf), int'(ovf_q.pop_front()));
        oidx = (oidx == EXP_W + MAN_L - 1) ? 0 : oidx + 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R8 out_valid", int'(out_valid), 0);
    check("R8 ovf", int'(ovf), 0);
    check("R8 in_ready", int'(in_ready), 1);
    @(posedge clk); #1;

    send_frame(12'd5,   0,  1, "R5");      // no carry
    send_frame(12'd40,  1,  0, "R4");      // carry, zero lead
    send_frame(12'd77, -1, -1, "R4");      // same-sign pair
    send_frame(12'd9,   1, -1, "R5");      // rewrite to +1
    send_frame(12'd300,-1,  1, "R5");      // rewrite to -1
    send_frame(12'hFFF, 1,  1, "R3");      // wraps, flag set
    send_frame(12'hFFF, 0,  0, "R6");      // no increment, flag clears, zero lead
    send_frame(12'd1,  -1,  0, "R4");
    bp_en = 1;                             // R7: random back-pressure
    send_frame(12'd2048, 1, 1, "R7");
    send_frame(12'd123,  0, -1, "R7");
    send_frame(12'hFFF, -1, -1, "R7");
    send_frame(12'd15,   1, -1, "R7");

    for (int i = 0; i < 2000 && exp_dq.size() != 0; i++) @(negedge clk);
    bp_en = 0;
    repeat (5) @(negedge clk);
    check("R1 frame digits drained", exp_dq.size(), 0);
    check("R1 frame boundary", oidx, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule